// File: doc/BRIEF.md
# HDLC Transmit Double-Pool Buffer

This block sits between a host processor and the bit-level HDLC transmit serializer. It holds outgoing bytes in two pools of 32 bytes each. The host loads bytes one at a time into the current fill pool. It then hands the block over with a send command, which also marks the data as a prepared frame or as transparent data and can carry an end-of-message mark. While the serializer drains one handed-over pool, the host can already fill the other.

The host learns when it may load by two means. A write-enable status level can be polled. A one-cycle pool-ready interrupt pulse fires whenever a fresh pool has just become available for loading. Writes made while loading is not allowed are dropped, and they raise a sticky overflow flag. A flush command returns both pools to empty. On the serializer side the block gives a valid/ready byte stream. The final byte of a block that was sent with end-of-message is flagged as last. Flag and CRC insertion and bit stuffing belong to the serializer and are not part of this block.

Top module: `hdlc_txq`

## Requirements
- R1: After reset, host_wen is 1 and pool_irq, ovf_flag and tx_valid are 0.
- R2: A host write made while host_wen is 1 stores the byte in the current fill pool. Once a pool holds 32 bytes, host_wen reads 0 from the next cycle on.
- R3: A host write made while host_wen is 0 is dropped, so no extra byte ever reaches the tx stream. It also sets ovf_flag on the next cycle, and ovf_flag then stays set until a flush.
- R4: cmd_code 2'b01 sends a prepared frame and 2'b10 sends transparent data. Either one hands over the fill pool only if that pool holds at least one byte, and loading then moves to the other pool. A send command on an empty pool has no effect. cmd_code 2'b00 is a no-op.
- R5: tx_valid is 1 while a handed-over pool remains. Bytes leave in the order they were written, and pools leave in the order they were handed over, one byte per cycle in which tx_valid and tx_ready are both 1. While tx_ready is 0, tx_data stays unchanged.
- R6: tx_last is 1 on the final byte of a block only if that block was sent with cmd_eom = 1. It is 0 on every other byte.
- R7: tx_frame is 1 for the bytes of a block sent with 2'b01 and 0 for the bytes of a block sent with 2'b10.
- R8: pool_irq pulses for one cycle, starting the cycle after a send command hands over a pool, if the new fill pool is free.
- R9: cmd_code 2'b11 (flush) empties both pools and stops the tx stream. On the next cycle host_wen is 1, ovf_flag is 0 and pool_irq pulses.
- R10: A host write issued in the same cycle as a send command is accepted and becomes the final byte of the block handed over.
- R11: When both pools have been handed over, host_wen is 0 and no pool-ready pulse fires. When the serializer takes the last byte of the older pool, host_wen returns to 1 and pool_irq pulses on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| cmd_code | input | 2 | 00 none, 01 send frame, 10 send transparent, 11 flush |
| cmd_eom | input | 1 | End-of-message mark for a send command |
| host_wen | output | 1 | Host may write to the fill pool |
| pool_irq | output | 1 | One-cycle pool-ready interrupt |
| ovf_flag | output | 1 | Sticky flag for a dropped write |
| tx_valid | output | 1 | Byte available to serializer |
| tx_ready | input | 1 | Serializer accepts byte |
| tx_data | output | 8 | Byte to serializer |
| tx_last | output | 1 | Final byte of an end-of-message block |
| tx_frame | output | 1 | Byte belongs to a prepared frame |

## Verification
Two pairs of functions can fall in one cycle. The first pair is a host write and a send command: the bench pulses wr_valid together with a send code and checks that the byte comes out as the flagged last byte of that block. The second pair is the serializer taking the final byte of the older pool while the host is blocked by two pools that are both handed over. There the bench checks, in the very next cycle, that host_wen rises and a single pool_irq pulse appears while the second pool begins streaming.

// File: rtl/hdlc_txq_pkg.sv
package hdlc_txq_pkg;
    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_FRAME = 2'b01,
        CMD_RAW   = 2'b10,
        CMD_FLUSH = 2'b11
    } txq_cmd_e;
endpackage

// File: rtl/hdlc_txq_mem.sv
module hdlc_txq_mem #(
    parameter int DATA_W     = 8,
    parameter int POOL_BYTES = 32,
    parameter int NUM_POOLS  = 2,
    localparam int PTR_W     = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
    localparam int IDX_W     = $clog2(POOL_BYTES),
    localparam int CNT_W     = $clog2(POOL_BYTES + 1)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [CNT_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  rptr,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH  = NUM_POOLS * POOL_BYTES;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] store [DEPTH];
    logic [ADDR_W-1:0] waddr, raddr;

    assign waddr = ADDR_W'(wptr) * ADDR_W'(POOL_BYTES) + ADDR_W'(widx);
    assign raddr = ADDR_W'(rptr) * ADDR_W'(POOL_BYTES) + ADDR_W'(ridx);

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/hdlc_txq_ctrl.sv
module hdlc_txq_ctrl
    import hdlc_txq_pkg::*;
#(
    parameter int POOL_BYTES = 32,
    parameter int NUM_POOLS  = 2,
    localparam int PTR_W     = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
    localparam int CNT_W     = $clog2(POOL_BYTES + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_valid,
    input  logic [1:0]                      cmd_code,
    input  logic                            cmd_eom,
    input  logic                            rel_valid,
    input  logic [PTR_W-1:0]                rel_ptr,
    output logic                            flush,
    output logic                            mem_we,
    output logic [PTR_W-1:0]                fill_ptr,
    output logic [NUM_POOLS-1:0][CNT_W-1:0] pool_cnt,
    output logic [NUM_POOLS-1:0]            pool_busy,
    output logic [NUM_POOLS-1:0]            pool_eom,
    output logic [NUM_POOLS-1:0]            pool_frame,
    output logic                            wen,
    output logic                            irq,
    output logic                            ovf
);
    typedef struct packed {
        logic [NUM_POOLS-1:0][CNT_W-1:0] cnt;
        logic [NUM_POOLS-1:0]            busy;
        logic [NUM_POOLS-1:0]            eom;
        logic [NUM_POOLS-1:0]            frame;
        logic [PTR_W-1:0]                fp;
        logic                            wen;
        logic                            irq;
        logic                            ovf;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    txq_cmd_e cmd;
    logic     is_send, wr_ok, commit;

    assign cmd     = txq_cmd_e'(cmd_code);
    assign flush   = (cmd == CMD_FLUSH);
    assign is_send = (cmd == CMD_FRAME) || (cmd == CMD_RAW);
    assign wr_ok   = wr_valid && st_q.wen && !flush;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        commit   = 1'b0;
        if (rel_valid) begin
            st_d.busy[rel_ptr] = 1'b0;
            st_d.cnt[rel_ptr]  = '0;
        end
        if (flush) begin
            st_d     = '0;
            st_d.wen = 1'b1;
            st_d.irq = 1'b1;
        end else begin
            if (wr_valid && !st_q.wen) st_d.ovf = 1'b1;
            if (wr_ok) st_d.cnt[st_q.fp] = st_q.cnt[st_q.fp] + 1'b1;
            commit = is_send && !st_q.busy[st_q.fp] && (st_d.cnt[st_q.fp] != '0);
            if (commit) begin
                st_d.busy[st_q.fp]  = 1'b1;
                st_d.eom[st_q.fp]   = cmd_eom;
                st_d.frame[st_q.fp] = (cmd == CMD_FRAME);
                st_d.fp = (st_q.fp == PTR_W'(NUM_POOLS - 1)) ? '0 : st_q.fp + 1'b1;
            end
            st_d.wen = !st_d.busy[st_d.fp] && (st_d.cnt[st_d.fp] < CNT_W'(POOL_BYTES));
            st_d.irq = st_d.wen && (commit || !st_q.wen);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.wen <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we     = wr_ok;
    assign fill_ptr   = st_q.fp;
    assign pool_cnt   = st_q.cnt;
    assign pool_busy  = st_q.busy;
    assign pool_eom   = st_q.eom;
    assign pool_frame = st_q.frame;
    assign wen        = st_q.wen;
    assign irq        = st_q.irq;
    assign ovf        = st_q.ovf;

    // R2: the byte that fills the pool closes it to the host
    p_full_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wen && !rel_valid && (cmd == CMD_NONE)
            && (pool_cnt[fill_ptr] == CNT_W'(POOL_BYTES - 1)) |=> !wen);

    // R3: a refused write raises the flag
    p_reject_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wen && !flush |=> ovf);

    // R3: the flag is sticky until flush
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !flush |=> ovf);

    // R8: a ready pulse only announces an open pool
    p_irq_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wen);

    // R9: flush reopens the host side and clears the flag
    p_flush_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> wen && !ovf && irq && (pool_busy == '0));
endmodule

// File: rtl/hdlc_txq_drain.sv
module hdlc_txq_drain #(
    parameter int POOL_BYTES = 32,
    parameter int NUM_POOLS  = 2,
    localparam int PTR_W     = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
    localparam int IDX_W     = $clog2(POOL_BYTES),
    localparam int CNT_W     = $clog2(POOL_BYTES + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic [NUM_POOLS-1:0][CNT_W-1:0] pool_cnt,
    input  logic [NUM_POOLS-1:0]            pool_busy,
    input  logic [NUM_POOLS-1:0]            pool_eom,
    input  logic [NUM_POOLS-1:0]            pool_frame,
    input  logic                            out_ready,
    output logic                            out_valid,
    output logic                            out_last,
    output logic                            out_frame,
    output logic [PTR_W-1:0]                rd_ptr,
    output logic [IDX_W-1:0]                rd_idx,
    output logic                            rel_valid,
    output logic [PTR_W-1:0]                rel_ptr
);
    typedef struct packed {
        logic [PTR_W-1:0] dp;
        logic [IDX_W-1:0] idx;
    } drain_st_t;

    drain_st_t dr_d, dr_q;
    logic      at_end, fire;

    assign out_valid = pool_busy[dr_q.dp];
    assign at_end    = (CNT_W'(dr_q.idx) == pool_cnt[dr_q.dp] - CNT_W'(1));
    assign out_last  = out_valid && at_end && pool_eom[dr_q.dp];
    assign out_frame = pool_frame[dr_q.dp];
    assign fire      = out_valid && out_ready;

    always_comb begin
        dr_d = dr_q;
        if (flush) begin
            dr_d = '0;
        end else if (fire) begin
            if (at_end) begin
                dr_d.idx = '0;
                dr_d.dp  = (dr_q.dp == PTR_W'(NUM_POOLS - 1)) ? '0 : dr_q.dp + 1'b1;
            end else begin
                dr_d.idx = dr_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dr_q <= '0;
        else        dr_q <= dr_d;
    end

    assign rd_ptr    = dr_q.dp;
    assign rd_idx    = dr_q.idx;
    assign rel_valid = fire && at_end && !flush;
    assign rel_ptr   = dr_q.dp;

    // R5: bytes of a pool step forward one by one
    p_byte_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !at_end && !flush |=> (rd_idx == $past(rd_idx) + 1'b1) && out_valid);

    // R5: a finished pool hands over to the next pool from its first byte
    p_pool_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |=> (rd_idx == '0) && (rd_ptr != $past(rd_ptr)));
endmodule

// File: rtl/hdlc_txq.sv
module hdlc_txq #(
    parameter int DATA_W     = 8,
    parameter int POOL_BYTES = 32,
    parameter int NUM_POOLS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cmd_code,
    input  logic              cmd_eom,
    output logic              host_wen,
    output logic              pool_irq,
    output logic              ovf_flag,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    output logic              tx_frame
);
    localparam int PTR_W = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1;
    localparam int IDX_W = $clog2(POOL_BYTES);
    localparam int CNT_W = $clog2(POOL_BYTES + 1);

    logic                            flush, mem_we, rel_valid;
    logic [PTR_W-1:0]                fill_ptr, rd_ptr, rel_ptr;
    logic [IDX_W-1:0]                rd_idx;
    logic [NUM_POOLS-1:0][CNT_W-1:0] pool_cnt;
    logic [NUM_POOLS-1:0]            pool_busy, pool_eom, pool_frame;

    hdlc_txq_ctrl #(.POOL_BYTES(POOL_BYTES), .NUM_POOLS(NUM_POOLS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .cmd_code(cmd_code),
        .cmd_eom(cmd_eom), .rel_valid(rel_valid), .rel_ptr(rel_ptr),
        .flush(flush), .mem_we(mem_we), .fill_ptr(fill_ptr), .pool_cnt(pool_cnt),
        .pool_busy(pool_busy), .pool_eom(pool_eom), .pool_frame(pool_frame),
        .wen(host_wen), .irq(pool_irq), .ovf(ovf_flag)
    );

    hdlc_txq_drain #(.POOL_BYTES(POOL_BYTES), .NUM_POOLS(NUM_POOLS)) u_drain (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pool_cnt(pool_cnt),
        .pool_busy(pool_busy), .pool_eom(pool_eom), .pool_frame(pool_frame),
        .out_ready(tx_ready), .out_valid(tx_valid), .out_last(tx_last),
        .out_frame(tx_frame), .rd_ptr(rd_ptr), .rd_idx(rd_idx),
        .rel_valid(rel_valid), .rel_ptr(rel_ptr)
    );

    hdlc_txq_mem #(.DATA_W(DATA_W), .POOL_BYTES(POOL_BYTES), .NUM_POOLS(NUM_POOLS)) u_mem (
        .clk(clk), .we(mem_we), .wptr(fill_ptr), .widx(pool_cnt[fill_ptr]),
        .wdata(wr_data), .rptr(rd_ptr), .ridx(rd_idx), .rdata(tx_data)
    );

    // R5: a stalled byte is held unchanged
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !flush |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R11: with every pool handed over the host is blocked
    p_all_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_busy == '1) |-> !host_wen && !pool_irq);
endmodule

// File: tb/hdlc_txq_bench.sv
module hdlc_txq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cmd_code = 2'b00;
    logic       cmd_eom = 1'b0;
    logic       tx_ready = 1'b0;
    logic       host_wen, pool_irq, ovf_flag, tx_valid, tx_last, tx_frame;
    logic [7:0] tx_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hdlc_txq u_hdlc_txq (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .cmd_code(cmd_code), .cmd_eom(cmd_eom), .host_wen(host_wen),
        .pool_irq(pool_irq), .ovf_flag(ovf_flag), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_frame(tx_frame)
    );

    typedef struct packed {
        logic [5:0] n;
        logic [1:0] cmd;
        logic       eom;
        logic [7:0] seed;
    } blk_t;

    localparam blk_t BLKS [5] = '{
        '{6'd1,  2'b01, 1'b1, 8'h10},
        '{6'd4,  2'b10, 1'b0, 8'h40},
        '{6'd7,  2'b01, 1'b0, 8'hA0},
        '{6'd3,  2'b10, 1'b1, 8'hF0},
        '{6'd12, 2'b01, 1'b1, 8'h55}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        wr_valid = 1'b1;
        wr_data  = b;
        tick();
        wr_valid = 1'b0;
    endtask

    task automatic send(input logic [1:0] c, input logic e);
        cmd_code = c;
        cmd_eom  = e;
        tick();
        cmd_code = 2'b00;
        cmd_eom  = 1'b0;
    endtask

    task automatic drain(input string req, input int n, input logic [7:0] seed,
                         input logic eom, input logic frame);
        tx_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            check({req, " valid"}, 32'(tx_valid), 32'd1);
            check({req, " data"}, 32'(tx_data), 32'(seed + 8'(i)));
            check({req, " R6 last"}, 32'(tx_last), 32'((i == n - 1) && eom));
            check({req, " R7 frame"}, 32'(tx_frame), 32'(frame));
            tick();
        end
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 wen", 32'(host_wen), 32'd1);
        check("R1 irq", 32'(pool_irq), 32'd0);
        check("R1 ovf", 32'(ovf_flag), 32'd0);
        check("R1 valid", 32'(tx_valid), 32'd0);

        // Table walk: R4, R5, R6, R7, R8
        foreach (BLKS[k]) begin
            for (int i = 0; i < int'(BLKS[k].n); i++) put(BLKS[k].seed + 8'(i));
            send(BLKS[k].cmd, BLKS[k].eom);
            check("R8 irq after send", 32'(pool_irq), 32'd1);
            drain("R5 table", int'(BLKS[k].n), BLKS[k].seed, BLKS[k].eom, BLKS[k].cmd == 2'b01);
            check("R5 stream ends", 32'(tx_valid), 32'd0);
        end

        // R2 fill to 32, R3 dropped write
        for (int i = 0; i < 32; i++) put(8'h80 + 8'(i));
        check("R2 wen low when full", 32'(host_wen), 32'd0);
        put(8'hEE);
        check("R3 ovf set", 32'(ovf_flag), 32'd1);
        send(2'b01, 1'b1);
        check("R8 irq", 32'(pool_irq), 32'd1);
        check("R2 wen after send", 32'(host_wen), 32'd1);
        drain("R2 full pool", 32, 8'h80, 1'b1, 1'b1);
        check("R3 no extra byte", 32'(tx_valid), 32'd0);
        check("R3 ovf sticky", 32'(ovf_flag), 32'd1);

        // R11 both pools handed over
        for (int i = 0; i < 3; i++) put(8'h20 + 8'(i));
        send(2'b01, 1'b1);
        check("R8 irq first", 32'(pool_irq), 32'd1);
        put(8'h30);
        put(8'h31);
        send(2'b10, 1'b0);
        check("R11 wen blocked", 32'(host_wen), 32'd0);
        check("R11 no irq", 32'(pool_irq), 32'd0);
        drain("R11 older", 3, 8'h20, 1'b1, 1'b1);
        check("R11 wen back", 32'(host_wen), 32'd1);
        check("R11 irq pulse", 32'(pool_irq), 32'd1);
        drain("R11 newer", 2, 8'h30, 1'b0, 1'b0);
        check("R11 irq single", 32'(pool_irq), 32'd0);

        // R4 send on empty pool
        send(2'b01, 1'b1);
        check("R4 empty no stream", 32'(tx_valid), 32'd0);
        check("R4 empty no irq", 32'(pool_irq), 32'd0);

        // R10 write together with send
        put(8'h61);
        wr_valid = 1'b1;
        wr_data  = 8'h62;
        send(2'b10, 1'b1);
        wr_valid = 1'b0;
        drain("R10 joint write", 2, 8'h61, 1'b1, 1'b0);
        check("R10 ends", 32'(tx_valid), 32'd0);

        // R5 stall holds data
        put(8'h71);
        put(8'h72);
        send(2'b01, 1'b1);
        for (int i = 0; i < 3; i++) begin
            check("R5 stall data", 32'(tx_data), 32'h71);
            check("R5 stall valid", 32'(tx_valid), 32'd1);
            tick();
        end
        drain("R5 after stall", 2, 8'h71, 1'b1, 1'b1);

        // R9 flush
        put(8'h91);
        put(8'h92);
        send(2'b01, 1'b1);
        put(8'h93);
        check("R9 ovf before", 32'(ovf_flag), 32'd1);
        send(2'b11, 1'b0);
        check("R9 valid", 32'(tx_valid), 32'd0);
        check("R9 wen", 32'(host_wen), 32'd1);
        check("R9 irq", 32'(pool_irq), 32'd1);
        check("R9 ovf", 32'(ovf_flag), 32'd0);
        put(8'hB4);
        send(2'b10, 1'b1);
        drain("R9 after flush", 1, 8'hB4, 1'b1, 1'b0);
        check("R9 old data gone", 32'(tx_valid), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule